// File: doc/BRIEF.md
# Write-Completion Polling Engine

This block sits on the host side of a byte-wide nonvolatile memory whose writes are self-timed. Once a separate writer has loaded a byte or a page, the engine is started with the address and value of the final byte written and a choice of completion test. It then runs plain read cycles on an active-low chip-select / output-enable / write-enable bus until the memory shows that its internal write is finished. A short settling delay follows, and then a one-cycle done pulse. If completion never shows, a cycle-count limit ends the attempt with an error pulse.

Two completion tests are offered. In data mode the engine compares the top bit of each read with the top bit of the saved data; while a write is running, the memory returns that bit inverted. In toggle mode no saved data is needed: the engine watches the next-to-top bit and declares completion when two reads in a row agree, because that bit flips on every read while a write is running. Access time, gap between reads, settle delay and timeout are all parameters counted in clock cycles.

Top module: `wpoll_engine`

## Requirements
- R1: After reset, busy_o, done_o and err_o are low and mem_ce_n, mem_oe_n and mem_we_n are all high.
- R2: While idle, start_i high at a clock edge captures addr_i, data_i and mode_i. busy_o rises at that edge and falls at the edge where done_o or err_o is raised. mem_addr shows the captured address during every read, and mem_ce_n stays high whenever busy_o is low.
- R3: Each read cycle drives mem_ce_n and mem_oe_n low together for exactly ACC_CYC cycles, with mem_we_n high at all times. Read data is sampled at the edge that ends the access.
- R4: Between consecutive reads of one operation, mem_ce_n and mem_oe_n stay high for exactly GAP_CYC cycles.
- R5: In data mode (mode_i = 0), the operation completes on the first read whose bit 7 equals bit 7 of the captured data.
- R6: In toggle mode (mode_i = 1), the operation completes on the first read whose bit 6 equals bit 6 of the previous read of the same operation. The first read never completes.
- R7: done_o is high for exactly one cycle, SETTLE_CYC cycles after the edge that ended the completing read, and the bus stays idle during that wait.
- R8: If no completion occurs within TIMEOUT_CYC cycles after the start edge, err_o pulses for one cycle at that edge, the bus returns high and no done_o is given. done_o and err_o are never high together.
- R9: start_i while busy_o is high is ignored. Address, data, mode and the outcome of the running operation are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a polling operation (taken only when idle) |
| mode_i | input | 1 | 0 = data-bit test, 1 = toggle-bit test |
| addr_i | input | AW | Address of the last byte written |
| data_i | input | DW | Value of the last byte written |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: write finished and settled |
| err_o | output | 1 | One-cycle pulse: timeout reached |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low (held high) |
| mem_addr | output | AW | Memory address |
| mem_rdata | input | DW | Data returned by the memory |

## Verification
The assertions assume that mem_rdata is stable by the last access cycle, and that start_i is a pulse given only after reset has been released. The access-length property also assumes that a read ends early only when a timeout does. The bench's memory model updates its busy state only at the clock edge after a read finishes, so returned data never changes within an access. Starts are driven on falling edges while idle, except for one deliberate start inside a running operation, which must be ignored. Operations that are meant to succeed use few enough busy reads to finish well inside the timeout.

// File: rtl/wpoll_pkg.sv
package wpoll_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_READ,
    PH_GAP,
    PH_SETTLE
  } phase_t;

  typedef enum logic {
    MODE_DATA   = 1'b0,
    MODE_TOGGLE = 1'b1
  } mode_t;
endpackage

// File: rtl/wpoll_tick.sv
// Cycle counter with a terminal value: hit is high in the cycle where the
// count equals 'last' while enabled.
module wpoll_tick #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] last,
  output logic         hit
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= cnt + 1'b1;
  end

  assign hit = en && (cnt == last);
endmodule

// File: rtl/wpoll_judge.sv
// Completion decision for one sampled read.
module wpoll_judge
  import wpoll_pkg::*;
(
  input  mode_t mode,
  input  logic  rd_flag,    // top status bit as read
  input  logic  rd_tog,     // toggling status bit as read
  input  logic  want_flag,  // top bit of the saved data
  input  logic  last_tog,   // toggling bit from the previous read
  input  logic  last_ok,    // a previous read exists in this operation
  output logic  complete
);
  always_comb begin
    if (mode == MODE_DATA) complete = (rd_flag == want_flag);
    else                   complete = last_ok && (rd_tog == last_tog);
  end
endmodule

// File: rtl/wpoll_engine.sv
module wpoll_engine
  import wpoll_pkg::*;
#(
  parameter int AW          = 15,
  parameter int DW          = 8,
  parameter int ACC_CYC     = 4,
  parameter int GAP_CYC     = 2,
  parameter int SETTLE_CYC  = 1000,
  parameter int TIMEOUT_CYC = 700000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata
);
  localparam int FLAG_BIT = DW - 1;
  localparam int TOG_BIT  = DW - 2;
  localparam int PH_MAX_A = (ACC_CYC > GAP_CYC) ? ACC_CYC : GAP_CYC;
  localparam int PH_MAX   = (PH_MAX_A > SETTLE_CYC) ? PH_MAX_A : SETTLE_CYC;
  localparam int PW       = $clog2(PH_MAX + 1);
  localparam int TW       = $clog2(TIMEOUT_CYC + 1);

  phase_t        state;
  mode_t         mode_q;
  logic          want_flag;
  logic          last_tog;
  logic          last_ok;
  logic [PW-1:0] ph_last;
  logic          ph_hit, ph_clr, ph_en;
  logic          tmo_hit, tmo_en, tmo_fire;
  logic          start_go;
  logic          complete;
  logic          polling;

  assign start_go = (state == PH_IDLE) && start_i;
  assign polling  = (state == PH_READ) || (state == PH_GAP);

  always_comb begin
    case (state)
      PH_READ:   ph_last = PW'(ACC_CYC - 1);
      PH_GAP:    ph_last = PW'(GAP_CYC - 1);
      PH_SETTLE: ph_last = PW'(SETTLE_CYC - 1);
      default:   ph_last = '0;
    endcase
  end

  wpoll_judge u_judge (
    .mode      (mode_q),
    .rd_flag   (mem_rdata[FLAG_BIT]),
    .rd_tog    (mem_rdata[TOG_BIT]),
    .want_flag (want_flag),
    .last_tog  (last_tog),
    .last_ok   (last_ok),
    .complete  (complete)
  );

  // Completion seen in the same cycle as the limit takes precedence.
  assign tmo_en   = polling;
  assign tmo_fire = tmo_hit && !((state == PH_READ) && ph_hit && complete);
  assign ph_en    = (state != PH_IDLE);
  assign ph_clr   = start_go || ph_hit || tmo_fire;

  wpoll_tick #(.W(PW)) u_phase (
    .clk  (clk),
    .rst  (rst),
    .clr  (ph_clr),
    .en   (ph_en),
    .last (ph_last),
    .hit  (ph_hit)
  );

  wpoll_tick #(.W(TW)) u_limit (
    .clk  (clk),
    .rst  (rst),
    .clr  (start_go),
    .en   (tmo_en),
    .last (TW'(TIMEOUT_CYC - 1)),
    .hit  (tmo_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PH_IDLE;
      mode_q    <= MODE_DATA;
      want_flag <= 1'b0;
      last_tog  <= 1'b0;
      last_ok   <= 1'b0;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_addr  <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (state)
        PH_IDLE: begin
          if (start_i) begin
            mode_q    <= mode_t'(mode_i);
            want_flag <= data_i[FLAG_BIT];
            mem_addr  <= addr_i;
            last_ok   <= 1'b0;
            busy_o    <= 1'b1;
            mem_ce_n  <= 1'b0;
            mem_oe_n  <= 1'b0;
            state     <= PH_READ;
          end
        end
        PH_READ: begin
          if (ph_hit) begin
            mem_ce_n <= 1'b1;
            mem_oe_n <= 1'b1;
            if (complete) begin
              state <= PH_SETTLE;
            end else if (tmo_fire) begin
              err_o  <= 1'b1;
              busy_o <= 1'b0;
              state  <= PH_IDLE;
            end else begin
              last_tog <= mem_rdata[TOG_BIT];
              last_ok  <= 1'b1;
              state    <= PH_GAP;
            end
          end else if (tmo_fire) begin
            mem_ce_n <= 1'b1;
            mem_oe_n <= 1'b1;
            err_o    <= 1'b1;
            busy_o   <= 1'b0;
            state    <= PH_IDLE;
          end
        end
        PH_GAP: begin
          if (tmo_fire) begin
            err_o  <= 1'b1;
            busy_o <= 1'b0;
            state  <= PH_IDLE;
          end else if (ph_hit) begin
            mem_ce_n <= 1'b0;
            mem_oe_n <= 1'b0;
            state    <= PH_READ;
          end
        end
        PH_SETTLE: begin
          if (ph_hit) begin
            done_o <= 1'b1;
            busy_o <= 1'b0;
            state  <= PH_IDLE;
          end
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  assign mem_we_n = 1'b1;
endmodule

// File: rtl/wpoll_chk.sv
module wpoll_chk #(
  parameter int AW      = 15,
  parameter int ACC_CYC = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic [AW-1:0] mem_addr
);
  int low_run;

  always_ff @(posedge clk) begin
    if (rst)           low_run <= 0;
    else if (mem_ce_n) low_run <= 0;
    else               low_run <= low_run + 1;
  end

  AST_WE_STAYS_HIGH: assert property (@(posedge clk) disable iff (rst)
    mem_we_n); // R3
  AST_CE_OE_PAIRED: assert property (@(posedge clk) disable iff (rst)
    mem_ce_n == mem_oe_n); // R3
  AST_READ_LENGTH: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_ce_n) && !err_o) |-> (low_run == ACC_CYC)); // R3
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> mem_ce_n); // R2
  AST_END_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (done_o || err_o)); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7
  AST_DONE_BUS_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> mem_ce_n); // R7
  AST_NO_DONE_WITH_ERR: assert property (@(posedge clk) disable iff (rst)
    !(done_o && err_o)); // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(mem_addr)); // R9
endmodule

bind wpoll_engine wpoll_chk #(.AW(AW), .ACC_CYC(ACC_CYC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .err_o    (err_o),
  .mem_ce_n (mem_ce_n),
  .mem_oe_n (mem_oe_n),
  .mem_we_n (mem_we_n),
  .mem_addr (mem_addr)
);

// File: tb/wpoll_engine_tb.sv
module wpoll_engine_tb;
  localparam int AW  = 15;
  localparam int DW  = 8;
  localparam int ACC = 3;
  localparam int GAP = 2;
  localparam int SET = 20;
  localparam int TMO = 200;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic          mode_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic          busy_o, done_o, err_o;
  logic          mem_ce_n, mem_oe_n, mem_we_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;

  always #5 clk = ~clk;

  wpoll_engine #(
    .AW(AW), .DW(DW), .ACC_CYC(ACC), .GAP_CYC(GAP),
    .SETTLE_CYC(SET), .TIMEOUT_CYC(TMO)
  ) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
    .addr_i(addr_i), .data_i(data_i), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  // Memory model: while busy, the top bit reads inverted and bit 6 flips
  // after each completed read.
  logic [DW-1:0] dev_data = '0;
  int            dev_left = 0;
  logic          tog = 1'b0;
  logic          ce_seen = 1'b1;

  always @(posedge clk) begin
    if (!ce_seen && mem_ce_n && dev_left > 0) begin
      dev_left <= dev_left - 1;
      tog      <= ~tog;
    end
    ce_seen <= mem_ce_n;
  end

  assign mem_rdata = (dev_left > 0) ? {~dev_data[7], tog, dev_data[5:0]} : dev_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit summary_done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  typedef struct {
    bit            is_err;
    int            reads;
    logic [AW-1:0] addr;
    string         tag;
  } exp_t;
  exp_t sbq[$];

  // Monitor
  int   reads = 0, low_len = 0, high_len = 0, k_cyc = 0, s_cyc = 0;
  bit   bad_acc = 0, bad_gap = 0, bad_we = 0, bad_addr = 0;
  logic prev_ce = 1'b1, prev_busy = 1'b0, prev_done = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_done && done_o) chk(0, "R7", "done longer than one cycle", 2, 1);
      if (!prev_busy && busy_o) begin
        reads = 0; k_cyc = 0;
        bad_acc = 0; bad_gap = 0; bad_we = 0; bad_addr = 0;
      end else begin
        k_cyc++;
      end
      if (!mem_we_n) bad_we = 1;
      if (prev_ce && !mem_ce_n) begin
        reads++;
        if (reads > 1 && high_len != GAP) bad_gap = 1;
        if (sbq.size() > 0 && mem_addr != sbq[0].addr) bad_addr = 1;
        low_len = 1;
      end else if (!mem_ce_n) begin
        low_len++;
      end
      if (!prev_ce && mem_ce_n) begin
        if (!err_o && low_len != ACC) bad_acc = 1;
        high_len = 1;
        s_cyc = 0;
      end else if (mem_ce_n) begin
        high_len++;
        s_cyc++;
      end
      if (done_o || err_o) begin
        if (sbq.size() == 0) begin
          chk(0, "R2", "end pulse with nothing expected", 1, 0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          chk(err_o == e.is_err, e.is_err ? "R8" : e.tag, "error outcome", int'(err_o), int'(e.is_err));
          chk(!(done_o && err_o), "R8", "done and err together", int'(done_o && err_o), 0);
          if (e.reads >= 0) chk(reads == e.reads, e.tag, "read count", reads, e.reads);
          if (e.is_err) chk(k_cyc == TMO, "R8", "cycles to timeout", k_cyc, TMO);
          else          chk(s_cyc == SET, "R7", "settle cycles", s_cyc, SET);
          chk(!busy_o, "R2", "busy at end pulse", int'(busy_o), 0);
          chk(!bad_acc && !bad_we, "R3", "read cycle shape", int'(bad_acc || bad_we), 0);
          chk(!bad_gap, "R4", "gap length", int'(bad_gap), 0);
          chk(!bad_addr, "R2", "read address", int'(bad_addr), 0);
        end
      end
      prev_ce   = mem_ce_n;
      prev_busy = busy_o;
      prev_done = done_o;
    end
  end

  // Driver
  task automatic run_op(input bit mode, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input int busy_reads,
                        input bit t0, input bit to, input bit poke,
                        input string tag);
    exp_t e;
    int   nexp;
    nexp = -1;
    if (!to) begin
      if (!mode) begin
        nexp = busy_reads + 1;
      end else begin
        logic pv, v;
        pv = 1'b0;
        for (int i = 1; i < 100; i++) begin
          v = (i <= busy_reads) ? (t0 ^ logic'((i - 1) % 2)) : d[6];
          if (i > 1 && v == pv) begin
            nexp = i;
            break;
          end
          pv = v;
        end
      end
    end
    e.is_err = to; e.reads = nexp; e.addr = a; e.tag = tag;
    sbq.push_back(e);
    dev_data = d;
    dev_left = to ? 100000 : busy_reads;
    tog      = t0;
    mode_i   = mode; addr_i = a; data_i = d; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    addr_i  = ~a;
    if (poke) begin
      repeat (6) @(negedge clk);
      chk(busy_o, "R9", "busy before extra start", int'(busy_o), 1);
      start_i = 1'b1; mode_i = ~mode; data_i = ~d; addr_i = ~a;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    repeat (4) @(negedge clk);
    dev_left = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o, "R1", "busy after reset", int'(busy_o), 0);
    chk(!done_o && !err_o, "R1", "pulses after reset", int'(done_o || err_o), 0);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1", "bus strobes after reset",
        int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);

    run_op(1'b0, 15'h1234, 8'h5A, 3, 1'b0, 1'b0, 1'b0, "R5");
    run_op(1'b0, 15'h0001, 8'hC3, 0, 1'b0, 1'b0, 1'b0, "R5");
    run_op(1'b0, 15'h7FFF, 8'h80, 5, 1'b1, 1'b0, 1'b0, "R5");
    run_op(1'b1, 15'h2AAA, 8'h40, 0, 1'b0, 1'b0, 1'b0, "R6");
    run_op(1'b1, 15'h0555, 8'h40, 4, 1'b0, 1'b0, 1'b0, "R6");
    run_op(1'b1, 15'h4321, 8'h00, 3, 1'b1, 1'b0, 1'b0, "R6");
    run_op(1'b1, 15'h1111, 8'hBF, 2, 1'b0, 1'b0, 1'b0, "R6");
    run_op(1'b0, 15'h3C3C, 8'h11, 6, 1'b0, 1'b0, 1'b1, "R9");
    run_op(1'b0, 15'h0F0F, 8'h22, 0, 1'b0, 1'b1, 1'b0, "R8");
    run_op(1'b1, 15'h00F0, 8'h7E, 0, 1'b1, 1'b1, 1'b0, "R8");
    run_op(1'b0, 15'h5555, 8'hA0, 2, 1'b0, 1'b0, 1'b0, "R5");

    chk(sbq.size() == 0, "R2", "outstanding operations", sbq.size(), 0);
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end
endmodule